// File: doc/BRIEF.md
# Mirrored Two-Read One-Write Register File

This block is a general-purpose register file that serves two operand reads and one result write in every clock cycle. It holds its registers in two identical storage copies. Each copy is a simple dual-port memory with one write port and one read port. Each write is steered to both copies with the same address and data, so the copies never differ. Read port A takes its data from copy 0 and read port B takes its data from copy 1. The two ports can therefore look at two unrelated registers in the same cycle.

Reads are registered. An address presented before a clock edge produces its data just after that edge. If a read and a write hit the same register in the same cycle, the read returns the value held before the write. The register contents are not cleared by reset; only the two read-data registers are. All three ports are plain per-cycle control inputs and outputs. No port carries a handshake and no port can stall, because each port completes one access every cycle by design.

Top module: `rf_mirror_2r1w`

## Requirements
- R1: A value written to register N through the write port (wr_en = 1) is returned on rd_data_a once rd_addr_a = N is presented in any later cycle.
- R2: A value written to register N is returned on rd_data_b once rd_addr_b = N is presented in any later cycle.
- R3: In a single cycle the two read ports return the contents of two different registers, each chosen only by its own address.
- R4: Read data is registered. Data for the address presented before clock edge k appears after edge k and does not follow an address change that happens between edges.
- R5: When a read and a write target the same register in the same cycle, the read returns the previous contents. The next read of that register returns the new value.
- R6: A cycle with wr_en = 0 leaves every register unchanged, whatever wr_addr and wr_data carry.
- R7: When both read ports present the same written register in the same cycle, they return equal data, because the two copies stay mirrored.
- R8: Under mixed traffic, with a write and two reads on every cycle, both read ports always agree with a reference array that receives every write.
- R9: While rst_n is low, rd_data_a and rd_data_b are 0. Register contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read-data registers |
| wr_en | input | 1 | Write strobe; stores wr_data into both copies this cycle |
| wr_addr | input | 8 | Register written |
| wr_data | input | 8 | Value written |
| rd_addr_a | input | 8 | Register read on port A (served from copy 0) |
| rd_data_a | output | 8 | Port A data, one cycle after rd_addr_a |
| rd_addr_b | input | 8 | Register read on port B (served from copy 1) |
| rd_data_b | output | 8 | Port B data, one cycle after rd_addr_b |

## Verification
Every read result is due on the clock edge that captures its address. The bench changes inputs 1 ns after a rising edge, waits for the next edge, and compares both ports 1 ns later. It predicts each result from a reference array taken before that cycle's write, which covers read-before-write. One scenario also samples just before the edge after moving the address, to show the output has not moved yet. The bound assertions look two cycles back, pairing a write with its later read through $past.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ADDR_W = 8;
  localparam int unsigned RF_DATA_W = 8;
  localparam int unsigned RF_COPIES = 2;
endpackage

// File: rtl/rf_wr_fanout.sv
module rf_wr_fanout #(
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W,
  parameter int unsigned COPIES = rf_pkg::RF_COPIES
) (
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [COPIES-1:0]              cp_en,
  output logic [COPIES-1:0][ADDR_W-1:0]  cp_addr,
  output logic [COPIES-1:0][DATA_W-1:0]  cp_data
);
  // One identical write request per copy keeps the copies mirrored.
  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    assign cp_en[g]   = wr_en;
    assign cp_addr[g] = wr_addr;
    assign cp_data[g] = wr_data;
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Storage is never reset.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Nonblocking read of the pre-edge contents gives read-before-write.
  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= store[raddr];
  end
endmodule

// File: rtl/rf_mirror_2r1w.sv
module rf_mirror_2r1w #(
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int unsigned NRD = 2;

  logic [NRD-1:0]             cp_en;
  logic [NRD-1:0][ADDR_W-1:0] cp_addr;
  logic [NRD-1:0][DATA_W-1:0] cp_data;
  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_data;

  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;
  assign rd_data_a  = rd_data[0];
  assign rd_data_b  = rd_data[1];

  rf_wr_fanout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COPIES(NRD)) u_fanout (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cp_en   (cp_en),
    .cp_addr (cp_addr),
    .cp_data (cp_data)
  );

  // Copy g serves read port g.
  for (genvar g = 0; g < NRD; g++) begin : g_bank
    rf_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cp_en[g]),
      .waddr (cp_addr[g]),
      .wdata (cp_data[g]),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end
endmodule

// File: rtl/rf_mirror_2r1w_chk.sv
module rf_mirror_2r1w_chk #(
  parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int unsigned DATA_W = rf_pkg::RF_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (wr_en) seen[wr_addr] <= 1'b1;
  end

  // R9: read outputs cleared by reset
  p_reset_out_r9: assert property (@(posedge clk)
    !rst_n |=> (rd_data_a == '0 && rd_data_b == '0));

  // R1: write then read on port A one cycle later
  p_write_read_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en, 2) && $past(rd_addr_a) == $past(wr_addr, 2)
     && !($past(wr_en) && $past(wr_addr) == $past(wr_addr, 2)))
    |-> rd_data_a == $past(wr_data, 2));

  // R2: write then read on port B one cycle later
  p_write_read_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en, 2) && $past(rd_addr_b) == $past(wr_addr, 2)
     && !($past(wr_en) && $past(wr_addr) == $past(wr_addr, 2)))
    |-> rd_data_b == $past(wr_data, 2));

  // R7: copies agree on a shared written address
  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_addr_a == rd_addr_b) && $past(seen[rd_addr_a]))
    |-> rd_data_a == rd_data_b);
endmodule

bind rf_mirror_2r1w rf_mirror_2r1w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b)
);

// File: tb/test_rf_mirror_2r1w.sv
`timescale 1ns/1ps
module test_rf_mirror_2r1w;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [7:0] rd_data_a, rd_data_b;

  int unsigned vectors = 0, miscompares = 0;
  logic [7:0] model [256];
  logic       known [256];
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rf_mirror_2r1w i_rf_mirror_2r1w (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One cycle: drive, clock, compare both ports with pre-write model contents.
  task automatic step(input logic we, input logic [7:0] wa, input logic [7:0] wd,
                      input logic [7:0] ra, input logic [7:0] rb, input string req);
    logic [7:0] ea, eb;
    logic ka, kb;
    ea = model[ra]; ka = known[ra];
    eb = model[rb]; kb = known[rb];
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    @(posedge clk); #1;
    if (we) begin model[wa] = wd; known[wa] = 1'b1; end
    wr_en = 1'b0;
    if (ka) check({req, " port A"}, rd_data_a, ea);
    if (kb) check({req, " port B"}, rd_data_b, eb);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset A", rd_data_a, 8'h00);
    check("R9 reset B", rd_data_b, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_fill;
    for (int i = 0; i < 256; i++)
      step(1'b1, 8'(i), 8'(i * 7 + 3), 8'(i), 8'(255 - i), "R1 fill");
  endtask

  task automatic t_port_a;
    step(1'b1, 8'h10, 8'hA5, 8'h00, 8'h01, "R1 write");
    step(1'b0, 8'h00, 8'h00, 8'h10, 8'h02, "R1 read A");
  endtask

  task automatic t_port_b;
    step(1'b1, 8'h20, 8'h5A, 8'h03, 8'h04, "R2 write");
    step(1'b0, 8'h00, 8'h00, 8'h05, 8'h20, "R2 read B");
  endtask

  task automatic t_dual;
    step(1'b0, 8'h00, 8'h00, 8'h10, 8'h20, "R3 two reads");
    step(1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, "R3 extremes");
  endtask

  task automatic t_latency;
    step(1'b0, 8'h00, 8'h00, 8'h10, 8'h20, "R4 setup");
    rd_addr_a = 8'h11; rd_addr_b = 8'h21;
    #2;
    check("R4 hold A", rd_data_a, model[8'h10]);
    check("R4 hold B", rd_data_b, model[8'h20]);
    @(posedge clk); #1;
    check("R4 next A", rd_data_a, model[8'h11]);
    check("R4 next B", rd_data_b, model[8'h21]);
  endtask

  task automatic t_rbw;
    check("R5 old", model[8'h30], 8'(8'h30 * 7 + 3));
    step(1'b1, 8'h30, 8'hC3, 8'h30, 8'h30, "R5 same-cycle");
    step(1'b0, 8'h00, 8'h00, 8'h30, 8'h30, "R5 after");
  endtask

  task automatic t_no_we;
    step(1'b0, 8'h40, 8'hEE, 8'h41, 8'h42, "R6 strobe low");
    step(1'b0, 8'h00, 8'h00, 8'h40, 8'h40, "R6 unchanged");
  endtask

  task automatic t_same;
    for (int i = 0; i < 8; i++)
      step(1'b0, 8'h00, 8'h00, 8'(i * 31), 8'(i * 31), "R7 mirror");
  endtask

  task automatic t_random;
    for (int i = 0; i < 2000; i++)
      step($urandom_range(1, 0) == 1, 8'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom), "R8 mixed");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin model[i] = '0; known[i] = 1'b0; end
    #1;
    t_reset;
    t_fill;
    t_port_a;
    t_port_b;
    t_dual;
    t_latency;
    t_rbw;
    t_no_we;
    t_same;
    t_random;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R9 reset again A", rd_data_a, 8'h00);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 8'h00, 8'h10, 8'h20, "R9 contents kept");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule